// File: doc/BRIEF.md
# Model-Railway Track Packet Transmitter

This block turns a switch setting into one complete locomotive command packet and drives it, bit by bit, onto a single track-signal line. Eight command switches are read through a fixed priority: the highest set switch names the command, and with no switch set a stop command is chosen. A start strobe seen while the block is idle captures the packet and begins the transmission. The block shows busy for the whole packet and pulses done once when the last bit has finished.

Each packet bit becomes one bit cell on the line: a low half followed by a high half of equal length. A zero has a long half and a one has a short half. Half lengths are counted in ticks of a timing strobe that is divided down from the system clock. The defaults are a 100-clock tick (1 us at 100 MHz), 100-tick zero halves and 58-tick one halves. Bit cells follow one another with no gap, and the tick divider restarts at every cell, so every cell of the same value has the same length.

Top module: `dcc_packet_tx`

## Requirements
- R1: After reset, and whenever no packet is being sent, `dcc_out`, `busy` and `done` are all 0. A reset during a packet stops it at once.
- R2: A packet is 51 bits, sent in this order: 23 ones, then a 0, the address byte, a 0, the command byte, a 0, the check byte and a final 1. Each byte goes out MSB first.
- R3: The address byte is always 8'h02.
- R4: The check byte is the bitwise XOR of the address byte and the command byte.
- R5: A zero bit is `dcc_out` low for ZERO_HALF*TICK_DIV clocks and then high for the same count. The first cell starts in the clock after the edge that accepted `start`. Each following cell starts directly after the one before it.
- R6: A one bit is `dcc_out` low for ONE_HALF*TICK_DIV clocks and then high for the same count.
- R7: The command byte comes from the highest set switch: bit7 8'h74, bit6 8'h54, bit5 8'h90, bit4 8'h80, bit3 8'hA4, bit2 8'hA0, bit1 8'h7F, bit0 8'h42.
- R8: With all switches at 0, the command byte is 8'h60 (stop).
- R9: `start` and `cmd_sw` are only read while `busy` is 0. A start strobe or a switch change during a packet has no effect on that packet, and it does not start another packet afterwards.
- R10: `busy` rises at the edge that accepts `start` and falls at the end of the last cell. `done` is high for exactly the one clock that follows that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_sw | input | 8 | Command-select switches, bit 7 has the highest priority |
| start | input | 1 | Send request, accepted only while idle |
| busy | output | 1 | A packet is being sent |
| done | output | 1 | One-clock pulse after the last bit |
| dcc_out | output | 1 | Serial track signal |

## Verification
The bench compares `dcc_out` clock by clock with a waveform it builds itself from the requirements, for every switch pattern in a table. The table includes patterns with several switches set, so a priority encoder that picks the wrong switch sends the wrong command bytes and the check byte also comes out wrong. During one packet the bench clears the switches and pulses start. A design that reads its inputs while busy would change the bits still to be sent, or would start a second packet straight after done. The bench also checks the busy fall and the one-clock done pulse, and resets the block in the middle of a packet. These catch an off-by-one bit count, a cell that is one tick too long, and a line left high after the last cell.

// File: rtl/dcc_tx_pkg.sv
package dcc_tx_pkg;
  localparam int PKT_BITS = 51;
  localparam int PREAMBLE_ONES = 23;
  localparam logic [7:0] LOCO_ADDR = 8'h02;
  localparam logic [7:0] CMD_STOP = 8'h60;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  // command byte attached to each switch position
  function automatic logic [7:0] cmd_for_switch(input int idx);
    logic [7:0] c;
    case (idx)
      7: c = 8'h74;
      6: c = 8'h54;
      5: c = 8'h90;
      4: c = 8'h80;
      3: c = 8'hA4;
      2: c = 8'hA0;
      1: c = 8'h7F;
      default: c = 8'h42;
    endcase
    return c;
  endfunction

  // highest set switch wins; scanning upward lets the later hit override
  function automatic logic [7:0] pick_command(input logic [7:0] sw);
    logic [7:0] c;
    c = CMD_STOP;
    for (int i = 0; i < 8; i++) begin
      if (sw[i]) c = cmd_for_switch(i);
    end
    return c;
  endfunction

  function automatic logic [PKT_BITS-1:0] build_packet(input logic [7:0] cmd);
    return {{PREAMBLE_ONES{1'b1}}, 1'b0, LOCO_ADDR, 1'b0, cmd, 1'b0,
            LOCO_ADDR ^ cmd, 1'b1};
  endfunction
endpackage

// File: rtl/dcc_tick_gen.sv
module dcc_tick_gen #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart || cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/dcc_bit_shaper.sv
module dcc_bit_shaper
  import dcc_tx_pkg::*;
#(
  parameter int ZERO_HALF = 100,
  parameter int ONE_HALF  = 58
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go,
  input  logic bit_val,
  output logic line,
  output logic fin
);
  localparam int HMAX = (ZERO_HALF > ONE_HALF) ? ZERO_HALF : ONE_HALF;
  localparam int PW = $clog2(HMAX + 1);

  phase_e st;
  logic cur_bit;
  logic [PW-1:0] ph;
  logic [PW-1:0] half_last;
  logic ph_end;

  assign half_last = cur_bit ? PW'(ONE_HALF - 1) : PW'(ZERO_HALF - 1);
  assign ph_end = tick && (ph == half_last);
  assign fin = (st == PH_HIGH) && ph_end;
  assign line = (st == PH_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PH_IDLE;
      cur_bit <= 1'b0;
      ph <= '0;
    end else if (go) begin
      st <= PH_LOW;
      cur_bit <= bit_val;
      ph <= '0;
    end else begin
      case (st)
        PH_LOW: begin
          if (ph_end) begin
            st <= PH_HIGH;
            ph <= '0;
          end else if (tick) ph <= ph + 1'b1;
        end
        PH_HIGH: begin
          if (ph_end) begin
            st <= PH_IDLE;
            ph <= '0;
          end else if (tick) ph <= ph + 1'b1;
        end
        default: ph <= '0;
      endcase
    end
  end

  // R5
  go_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == PH_IDLE || fin));
  // R6
  ph_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PH_IDLE) |-> (ph <= half_last));
  // R6
  low_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_LOW && !tick && !go) |=> (st == PH_LOW));
endmodule

// File: rtl/dcc_packet_seq.sv
module dcc_packet_seq #(
  parameter int N = 51
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] pkt,
  input  logic         fin,
  output logic         go,
  output logic         bit_val,
  output logic         busy,
  output logic         done
);
  localparam int LW = $clog2(N + 1);

  logic [N-1:0] sr;
  logic [LW-1:0] left;
  logic last;
  logic accept;

  assign last = (left == LW'(1));
  assign accept = !busy && start;
  assign go = accept || (fin && !last);
  assign bit_val = busy ? sr[N-2] : pkt[N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
      left <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= fin && last;
      if (accept) begin
        busy <= 1'b1;
        sr <= pkt;
        left <= LW'(N);
      end else if (fin) begin
        if (last) busy <= 1'b0;
        else begin
          sr <= sr << 1;
          left <= left - 1'b1;
        end
      end
    end
  end

  // R10
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> $stable(sr));
endmodule

// File: rtl/dcc_packet_tx.sv
module dcc_packet_tx
  import dcc_tx_pkg::*;
#(
  parameter int TICK_DIV  = 100,
  parameter int ZERO_HALF = 100,
  parameter int ONE_HALF  = 58
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cmd_sw,
  input  logic       start,
  output logic       busy,
  output logic       done,
  output logic       dcc_out
);
  logic [PKT_BITS-1:0] pkt;
  logic tick, go, bit_val, fin;

  assign pkt = build_packet(pick_command(cmd_sw));

  dcc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(go), .tick(tick)
  );

  dcc_packet_seq #(.N(PKT_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt(pkt), .fin(fin),
    .go(go), .bit_val(bit_val), .busy(busy), .done(done)
  );

  dcc_bit_shaper #(.ZERO_HALF(ZERO_HALF), .ONE_HALF(ONE_HALF)) u_shape (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .bit_val(bit_val),
    .line(dcc_out), .fin(fin)
  );

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dcc_out);
  // R10
  fin_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> busy);
endmodule

// File: tb/test_dcc_packet_tx.sv
module test_dcc_packet_tx;
  localparam int DIV = 2;
  localparam int ZH = 5;
  localparam int OH = 3;
  localparam int TZ = ZH * DIV;
  localparam int TO = OH * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cmd_sw = 8'h00;
  logic start = 1'b0;
  logic busy, done, dcc_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dcc_packet_tx #(.TICK_DIV(DIV), .ZERO_HALF(ZH), .ONE_HALF(OH)) i_dcc_packet_tx (
    .clk(clk), .rst_n(rst_n), .cmd_sw(cmd_sw), .start(start),
    .busy(busy), .done(done), .dcc_out(dcc_out)
  );

  // switch pattern in [15:8], expected command byte in [7:0]
  localparam logic [15:0] VEC [12] = '{
    {8'h80, 8'h74}, {8'hFF, 8'h74}, {8'h40, 8'h54}, {8'h60, 8'h54},
    {8'h20, 8'h90}, {8'h10, 8'h80}, {8'h08, 8'hA4}, {8'h04, 8'hA0},
    {8'h02, 8'h7F}, {8'h03, 8'h7F}, {8'h01, 8'h42}, {8'h00, 8'h60}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] sw, input logic [7:0] cmd,
                      input bit disturb, input string tag);
    logic [50:0] exp;
    int mism = 0;
    int first_bad = -1;
    int bsy_bad = 0;
    int cyc = 0;
    exp = {23'h7FFFFF, 1'b0, 8'h02, 1'b0, cmd, 1'b0, 8'h02 ^ cmd, 1'b1};
    @(negedge clk);
    cmd_sw = sw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 50; i >= 0; i--) begin
      for (int h = 0; h < 2; h++) begin
        for (int c = 0; c < (exp[i] ? TO : TZ); c++) begin
          if (dcc_out !== h[0]) begin
            mism++;
            if (first_bad < 0) first_bad = cyc;
          end
          if (busy !== 1'b1) bsy_bad++;
          if (disturb && cyc == 40) begin
            cmd_sw = ~sw;
            start = 1'b1;
          end
          if (disturb && cyc == 41) start = 1'b0;
          @(negedge clk);
          cyc++;
        end
      end
    end
    chk(mism == 0, tag, longint'(first_bad), -1);
    chk(bsy_bad == 0, "R10 busy during packet", bsy_bad, 0);
    chk(done === 1'b1 && busy === 1'b0, "R10 done at end", {busy, done}, 2'b01);
    @(negedge clk);
    chk(done === 1'b0 && dcc_out === 1'b0, "R10 R1 done single, line low",
        {done, dcc_out}, 2'b00);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dcc_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 in reset",
        {dcc_out, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dcc_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 after reset",
        {dcc_out, busy, done}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 via full waveform comparison
    for (int v = 0; v < 12; v++) begin
      send(VEC[v][15:8], VEC[v][7:0], 1'b0, "R2 R3 R4 R5 R6 R7 R8 waveform");
    end

    // R9: switch change and start pulse mid packet ignored
    send(8'h80, 8'h74, 1'b1, "R9 packet unchanged by mid-packet inputs");
    cmd_sw = 8'h00;
    begin
      int extra = 0;
      for (int k = 0; k < 8; k++) begin
        if (busy !== 1'b0 || dcc_out !== 1'b0) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R9 no packet started by busy-time strobe", extra, 0);
    end

    // R8 again with stop after change
    send(8'h00, 8'h60, 1'b0, "R8 stop packet");

    // R1: reset in mid packet
    cmd_sw = 8'h40;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy === 1'b1, "R10 busy before mid reset", busy, 1);
    rst_n = 1'b0;
    #1;
    chk(dcc_out === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 mid-packet reset",
        {dcc_out, busy, done}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dcc_out === 1'b0 && busy === 1'b0, "R1 idle after reset release",
        {dcc_out, busy}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule